// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synchronous static RAM. Its word is four 9-bit byte lanes, 36 bits in all, and its depth is set by a parameter. On the rising edge the block captures a command. The data for that command moves one clock later. Reads are flow-through, so the array output reaches the read bus in the cycle after the command with no output register on the way. Writes pick up their data on the next edge and commit it to the array one edge after that. Because of this pipelining, a read can follow a write directly with no idle cycle on the data buses. When a read hits a write that has not yet committed, the pending bytes are forwarded to the read path.

A load captures a new base address. An advance step continues the burst in progress, stepping the two low address bits in linear or interleaved order. An active-low clock enable or a high sleep input freezes the whole block as if the edge had not occurred. An asynchronous output enable gates the read drive. A synchronous reset returns the pipeline to idle and leaves the array contents unchanged.

Top module: `zbt_sram`

## Requirements
- R1: A new command is captured on a rising edge only when `clk_en_n`=0, `adv_ld`=0, `sel1_n`=0, `sel2_n`=0 and `sel_hi`=1. A write attempted with any select inactive changes no array word.
- R2: `rd_wr`=1 selects a read. In the cycle after the read is captured, `rdata_oe`=1 and `rdata` shows the addressed word (when `oe_n`=0).
- R3: `rd_wr`=0 selects a write. `wdata` is sampled on the next active edge. Only lanes with `byte_we_n[b]`=0 are stored, and lane b is bits [9b+8:9b].
- R4: On read cycles `byte_we_n` has no effect on the array.
- R5: With `clk_en_n`=1 all other synchronous inputs are ignored. The outputs and any pending access hold.
- R6: A load cycle with the device deselected leaves `rdata_oe`=0 in the following cycle.
- R7: With `oe_n`=1, `rdata_oe`=0 and `rdata`=0 whatever the cycle type.
- R8: `adv_ld`=1 during a burst keeps the burst's direction, ignores `addr` and advances step k. The low two address bits become (base+k) mod 4 when `burst_ilv`=0 and base XOR k when `burst_ilv`=1. Advancing with no burst in progress stays idle.
- R9: `sleep`=1 freezes the block like a clock-enable stall, and the array contents are retained.
- R10: A read captured right after a write to the same address returns the newly written bytes, with no dead cycle between them.
- R11: Synchronous `rst` clears the pipeline so that `rdata_oe`=0. It does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Sleep, freezes the block while high |
| sel1_n | input | 1 | Chip select, active low |
| sel2_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| adv_ld | input | 1 | 0 = load a new command, 1 = advance the burst |
| rd_wr | input | 1 | 1 = read, 0 = write |
| byte_we_n | input | 4 | Per-lane write enables, active low |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr | input | 6 | Word address |
| wdata | input | 36 | Write data, sampled one edge after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Read data, flow-through |
| rdata_oe | output | 1 | Read bus drive enable |

## Verification
The two functions that share a cycle are a read being presented on the output and a late write still waiting in the write buffer for the same word. When they coincide, the read must take the pending lanes and fall back to the array for the lanes that are masked. The bench sets this up with directed write-then-read pairs to one address, some with partial masks and some with a stall wedged between them. A random phase draws addresses from a narrow range so that such collisions come up often. A bench model that stores writes at their data edge judges every cycle, so it needs no forwarding of its own to predict the result.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
   typedef enum logic {DIR_WR = 1'b0, DIR_RD = 1'b1} dir_e;

   function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic ilv);
      return ilv ? (base ^ step) : (base + step);
   endfunction
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl #(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 4,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              adv_ld,
   input  logic              selected,
   input  logic              rd_wr,
   input  logic [LANES-1:0]  be_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              burst_ilv,
   output logic              p_valid,
   output logic              p_write,
   output logic [ADDR_W-1:0] p_addr,
   output logic [LANES-1:0]  p_mask
);
   import zbt_pkg::*;

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] step_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         p_valid <= 1'b0;
         p_write <= 1'b0;
         step_q  <= '0;
      end else if (active) begin
         if (!adv_ld) begin
            p_valid <= selected;
            p_write <= (dir_e'(rd_wr) == DIR_WR);
            base_q  <= addr;
            step_q  <= '0;
            p_mask  <= ~be_n;
         end else if (p_valid) begin
            step_q  <= step_q + 1'b1;
            p_mask  <= ~be_n;
         end
      end
   end

   generate
      if (BURST_W == 2) begin : g_std_burst
         assign p_addr = {base_q[ADDR_W-1:BURST_W],
                          burst_lo(base_q[1:0], step_q, burst_ilv)};
      end else begin : g_gen_burst
         assign p_addr = {base_q[ADDR_W-1:BURST_W],
                          burst_ilv ? (base_q[BURST_W-1:0] ^ step_q)
                                    : (base_q[BURST_W-1:0] + step_q)};
      end
   endgenerate

   // R6
   deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (active && !adv_ld && !selected) |=> !p_valid);
   // R8
   burst_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (active && adv_ld && p_valid) |=> (p_valid && (p_write == $past(p_write))));
   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !active |=> ($stable(p_valid) && $stable(p_write) && $stable(p_mask)));
endmodule

// File: rtl/zbt_wbuf.sv
module zbt_wbuf #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              p_valid,
   input  logic              p_write,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [LANES-1:0]  p_mask,
   input  logic [WORD_W-1:0] wdata,
   output logic              w_valid,
   output logic [ADDR_W-1:0] w_addr,
   output logic [LANES-1:0]  w_mask,
   output logic [WORD_W-1:0] w_data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         w_valid <= 1'b0;
      end else if (active) begin
         w_valid <= p_valid && p_write;
         w_addr  <= p_addr;
         w_mask  <= p_mask;
         w_data  <= wdata;
      end
   end

   // R3
   late_write_chk: assert property (@(posedge clk) disable iff (rst)
      (active && p_valid && p_write) |=> w_valid);
   // R9
   frozen_buf_chk: assert property (@(posedge clk) disable iff (rst)
      !active |=> ($stable(w_valid) && $stable(w_data) && $stable(w_addr)));
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    commit,
   input  logic [ADDR_W-1:0]       w_addr,
   input  logic [LANES-1:0]        w_mask,
   input  logic [LANES*LANE_W-1:0] w_data,
   input  logic [ADDR_W-1:0]       r_addr,
   output logic [LANES*LANE_W-1:0] r_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [LANES*LANE_W-1:0] mem [DEPTH];

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk) begin
         if (commit && w_mask[b])
            mem[w_addr][b*LANE_W +: LANE_W] <= w_data[b*LANE_W +: LANE_W];
      end
   end

   assign r_data = mem[r_addr];
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clk_en_n,
   input  logic                    sleep,
   input  logic                    sel1_n,
   input  logic                    sel2_n,
   input  logic                    sel_hi,
   input  logic                    adv_ld,
   input  logic                    rd_wr,
   input  logic [LANES-1:0]        byte_we_n,
   input  logic                    burst_ilv,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    oe_n,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);
   localparam int WORD_W = LANES * LANE_W;

   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("zbt_sram: ADDR_W must exceed BURST_W");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("zbt_sram: LANES and LANE_W must be positive");
   end

   logic              active, selected;
   logic              p_valid, p_write, w_valid;
   logic [ADDR_W-1:0] p_addr, w_addr;
   logic [LANES-1:0]  p_mask, w_mask;
   logic [WORD_W-1:0] w_data, arr_data, fwd_data;

   assign active   = !clk_en_n && !sleep;
   assign selected = !sel1_n && !sel2_n && sel_hi;

   zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
      .clk(clk), .rst(rst), .active(active), .adv_ld(adv_ld),
      .selected(selected), .rd_wr(rd_wr), .be_n(byte_we_n), .addr(addr),
      .burst_ilv(burst_ilv), .p_valid(p_valid), .p_write(p_write),
      .p_addr(p_addr), .p_mask(p_mask));

   zbt_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .WORD_W(WORD_W)) u_wbuf (
      .clk(clk), .rst(rst), .active(active), .p_valid(p_valid),
      .p_write(p_write), .p_addr(p_addr), .p_mask(p_mask), .wdata(wdata),
      .w_valid(w_valid), .w_addr(w_addr), .w_mask(w_mask), .w_data(w_data));

   zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .commit(active && w_valid), .w_addr(w_addr),
      .w_mask(w_mask), .w_data(w_data), .r_addr(p_addr), .r_data(arr_data));

   // R10: lanes of a pending write override the array on an address hit
   for (genvar b = 0; b < LANES; b++) begin : g_fwd
      assign fwd_data[b*LANE_W +: LANE_W] =
         (w_valid && (w_addr == p_addr) && w_mask[b]) ? w_data[b*LANE_W +: LANE_W]
                                                      : arr_data[b*LANE_W +: LANE_W];
   end

   assign rdata_oe = p_valid && !p_write && !oe_n;
   assign rdata    = rdata_oe ? fwd_data : '0;

   // R7
   released_bus_chk: assert property (@(posedge clk) disable iff (rst)
      !rdata_oe |-> (rdata == '0));
   // R11
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> !rdata_oe);
endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        clk_en_n = 1'b0, sleep = 1'b0;
   logic        sel1_n = 1'b0, sel2_n = 1'b0, sel_hi = 1'b1;
   logic        adv_ld = 1'b0, rd_wr = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
   logic [3:0]  byte_we_n = 4'hF;
   logic [5:0]  addr = '0;
   logic [35:0] wdata = '0;
   logic [35:0] rdata;
   logic        rdata_oe;

   int    checks = 0, failures = 0, cycles = 0;
   bit    armed = 0, done = 0;
   string cur_tag = "R11";

   // bench model: write stored at its data edge
   logic [35:0] mm [64];
   logic        mv = 1'b0, mw = 1'b0;
   logic [5:0]  mbase = '0, maddr = '0;
   logic [1:0]  mk = '0;
   logic [3:0]  mmask = '0;

   always #5 clk = ~clk;

   zbt_sram u_dut (
      .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sleep(sleep),
      .sel1_n(sel1_n), .sel2_n(sel2_n), .sel_hi(sel_hi), .adv_ld(adv_ld),
      .rd_wr(rd_wr), .byte_we_n(byte_we_n), .burst_ilv(burst_ilv),
      .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata),
      .rdata_oe(rdata_oe));

   function automatic logic [5:0] step_addr(input logic [5:0] b, input logic [1:0] k,
                                            input logic ilv);
      logic [1:0] lo;
      lo = ilv ? (b[1:0] ^ k) : (b[1:0] + k);
      return {b[5:2], lo};
   endfunction

   function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] d,
                                         input logic [3:0] m);
      logic [35:0] r;
      r = old;
      for (int b = 0; b < 4; b++) if (m[b]) r[b*9 +: 9] = d[b*9 +: 9];
      return r;
   endfunction

   initial for (int i = 0; i < 64; i++) mm[i] = 'x;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst) begin
         mv = 1'b0;
         armed <= 1'b1;
      end else if (!clk_en_n && !sleep) begin
         if (mv && mw) mm[maddr] = merge(mm[maddr], wdata, mmask);
         if (!adv_ld) begin
            mv = !sel1_n && !sel2_n && sel_hi;
            mw = !rd_wr;
            mbase = addr;
            mk = '0;
            mmask = ~byte_we_n;
         end else if (mv) begin
            mk = mk + 2'd1;
            mmask = ~byte_we_n;
         end
         maddr = step_addr(mbase, mk, burst_ilv);
      end
   end

   // output comparison, away from the rising edge
   always @(negedge clk) begin
      logic        e_oe;
      logic [35:0] e_d;
      if (armed && !rst && !done) begin
         e_oe = mv && !mw && !oe_n;
         e_d  = e_oe ? mm[maddr] : 36'h0;
         checks++;
         if (rdata_oe !== e_oe || rdata !== e_d) begin
            failures++;
            $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h (cycle %0d)",
                     cur_tag, rdata_oe, rdata, e_oe, e_d, cycles);
         end
      end
   end

   task automatic cmd(input logic adv, input logic rw, input logic [3:0] be,
                      input logic [5:0] a, input logic [35:0] d,
                      input logic cen_n = 1'b0, input logic slp = 1'b0,
                      input logic oe = 1'b0, input logic sel = 1'b1);
      @(negedge clk); #1;
      adv_ld = adv; rd_wr = rw; byte_we_n = be; addr = a; wdata = d;
      clk_en_n = cen_n; sleep = slp; oe_n = oe;
      sel1_n = !sel; sel2_n = 1'b0; sel_hi = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cmd(1'b0, 1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0017));
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;
      // R11 reset state checked by the comparator
      idle(2);

      // R3 full-word writes, R2 reads back
      cur_tag = "R3";
      for (int i = 0; i < 8; i++) cmd(1'b0, 1'b0, 4'h0, 6'(i), (i == 0) ? 36'h0 : 36'(i) * 36'h1_1111_1111);
      cmd(1'b0, 1'b1, 4'hF, 6'd0, 36'h7_7777_7777);
      cur_tag = "R2";
      for (int i = 0; i < 8; i++) cmd(1'b0, 1'b1, 4'h0, 6'(i), 36'h0);
      // R3 partial lanes: only lanes 0 and 2
      cur_tag = "R3";
      cmd(1'b0, 1'b0, 4'b1010, 6'd3, 36'h0);
      cmd(1'b0, 1'b1, 4'hF, 6'd3, 36'hA_BCDE_F012);
      // R10 write then read same word, partial mask forwarded
      cur_tag = "R10";
      cmd(1'b0, 1'b0, 4'b0110, 6'd5, 36'h0);
      cmd(1'b0, 1'b1, 4'hF, 6'd5, 36'h1_2345_6789);
      cmd(1'b0, 1'b1, 4'hF, 6'd5, 36'h0);
      // R4 byte enables low during a read
      cur_tag = "R4";
      cmd(1'b0, 1'b1, 4'h0, 6'd6, 36'h0);
      cmd(1'b0, 1'b1, 4'h0, 6'd6, 36'hF_FFFF_FFFF);
      cmd(1'b0, 1'b1, 4'hF, 6'd6, 36'h0);
      // R5 stall between write command and its data
      cur_tag = "R5";
      cmd(1'b0, 1'b0, 4'h0, 6'd7, 36'h0);
      cmd(1'b0, 1'b1, 4'h0, 6'd1, 36'hD_EAD0_0000, 1'b1);
      cmd(1'b0, 1'b1, 4'h0, 6'd7, 36'h5_5555_AAAA);
      cmd(1'b0, 1'b1, 4'h0, 6'd2, 36'h0, 1'b1);
      cmd(1'b0, 1'b1, 4'h0, 6'd7, 36'h0);
      // R9 sleep freezes, array kept
      cur_tag = "R9";
      cmd(1'b0, 1'b1, 4'hF, 6'd3, 36'h0, 1'b0, 1'b1);
      cmd(1'b0, 1'b0, 4'h0, 6'd3, 36'h0, 1'b0, 1'b1);
      cmd(1'b0, 1'b1, 4'hF, 6'd3, 36'h0);
      // R1 write with a select inactive stores nothing
      cur_tag = "R1";
      cmd(1'b0, 1'b0, 4'h0, 6'd4, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      cmd(1'b0, 1'b1, 4'hF, 6'd4, 36'h3_3333_0000);
      cmd(1'b0, 1'b1, 4'hF, 6'd4, 36'h0);
      // R6 deselect after a read
      cur_tag = "R6";
      cmd(1'b0, 1'b1, 4'hF, 6'd2, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      idle(1);
      // R7 output enable high over a read
      cur_tag = "R7";
      cmd(1'b0, 1'b1, 4'hF, 6'd1, 36'h0);
      cmd(1'b0, 1'b1, 4'hF, 6'd1, 36'h0, 1'b0, 1'b0, 1'b1);
      cmd(1'b0, 1'b1, 4'hF, 6'd1, 36'h0);
      // R8 bursts, linear then interleaved
      cur_tag = "R8";
      for (int o = 0; o < 2; o++) begin
         idle(1);
         cmd(1'b1, 1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0);
         burst_ilv = o[0];
         cmd(1'b0, 1'b0, 4'h0, 6'd22 + 6'(o * 8), 36'h0);
         for (int k = 1; k < 6; k++)
            cmd(1'b1, 1'b1, 4'h0, 6'd63, 36'(k) * 36'h0_1010_1011 + 36'(o));
         cmd(1'b0, 1'b1, 4'hF, 6'd22 + 6'(o * 8), 36'h9_9999_9999);
         for (int k = 1; k < 5; k++) cmd(1'b1, 1'b0, 4'h0, 6'd0, 36'h0);
         for (int k = 0; k < 4; k++) cmd(1'b0, 1'b1, 4'hF, 6'd20 + 6'(o * 8) + 6'(k), 36'h0);
      end
      // R11 reset mid-stream keeps the array
      cur_tag = "R11";
      cmd(1'b0, 1'b1, 4'hF, 6'd5, 36'h0);
      @(negedge clk); #1 rst = 1'b1;
      @(negedge clk); #1 rst = 1'b0;
      cmd(1'b0, 1'b1, 4'hF, 6'd5, 36'h0);
      cmd(1'b0, 1'b1, 4'hF, 6'd3, 36'h0);
      // random mix, both burst orders, R10 collisions common
      for (int ph = 0; ph < 2; ph++) begin
         cur_tag = (ph == 0) ? "R10 random linear" : "R10 random interleaved";
         idle(1);
         cmd(1'b1, 1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0);
         burst_ilv = ph[0];
         for (int i = 0; i < 3000; i++)
            cmd(($urandom % 10) < 4, $urandom % 2, 4'($urandom), 6'($urandom % 12),
                {4'($urandom), 32'($urandom)}, ($urandom % 10) == 0,
                ($urandom % 20) == 0, ($urandom % 10) == 0, ($urandom % 10) < 8);
      end
      idle(2);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule